// File: doc/BRIEF.md
# Programmable Parallel I/O Port Controller

This block sits between a processor bus and three byte-wide peripheral ports. The processor reaches it through an 8-bit data path with chip select, read strobe, write strobe and two address bits. The processor bus is carried as separate input, output and output-enable signals, and a pad ring would merge them into one bidirectional bus. Ports A and B are full bytes. Port C is treated as two nibbles, and each nibble has its own direction. Every port pin has its own output value and its own output-enable, so the pad drivers can be tri-stated.

A single control register can only be written. Its top bit selects what a write to it means. With the top bit at 1, the write loads a new direction setup for every port and clears every output latch. With the top bit at 0, the write sets or clears one chosen bit of port C and leaves the configuration alone. Only simple unhandshaked transfers are built here. The group mode fields are accepted but do not change behaviour.

Top module: `ppio_ctrl`

## Requirements
- R1: Address 0 selects port A, address 1 selects port B, address 2 selects port C and address 3 selects the control register. A write takes effect on the rising clock edge at which cs_n and wr_n are both low.
- R2: An output latch keeps the last value written to it after the write strobe is released.
- R3: After reset every output-enable is 0, so all ports are inputs, and every output latch is 0.
- R4: A control write with bit 7 = 1 sets the directions, where 1 means input and 0 means output. Bit 4 sets port A, bit 1 sets port B, bit 3 sets the port C upper nibble (pins 7:4) and bit 0 sets the port C lower nibble (pins 3:0). Every pin of an output port or nibble has its output-enable set to 1.
- R5: A control write with bit 7 = 1 clears the output latches of ports A, B and C to 0.
- R6: A control write with bit 7 = 0 writes bit 0 of the data into port C latch bit number data[3:1]. All other latch bits and all directions stay unchanged.
- R7: A read returns the live pin value for a port or nibble set as input. It returns the latched value for a port or nibble set as output. Port C is chosen per nibble.
- R8: dbus_oe is 1 only while cs_n and rd_n are both low.
- R9: A read of address 3 returns 0x00, because the control register cannot be read back.
- R10: A write strobe with cs_n high changes no latch and no direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| dbus_i | input | 8 | Write data from the processor |
| dbus_o | output | 8 | Read data to the processor |
| dbus_oe | output | 1 | Drive enable for the read data |
| pa_i | input | 8 | Port A pin values |
| pa_o | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A per-pin output-enable |
| pb_i | input | 8 | Port B pin values |
| pb_o | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B per-pin output-enable |
| pc_i | input | 8 | Port C pin values |
| pc_o | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C per-pin output-enable |

## Verification
The bench sets the two port C nibbles to opposite directions and reads back a mixed byte. A design that picks port C's source for the whole byte would return pin data or latch data in the wrong nibble. It issues bit set/reset writes to bits that are not at either end of port C. A design that decodes the wrong index, or that resets the configuration, would change other bits or drop port directions. A new mode write follows after the latches hold data, and a latch that survives it would be seen on the port outputs. Writes to a port set as input, strobes with chip select inactive, and a read of the control address check that none of them leaks into a read or an output.

// File: rtl/ppio_pkg.sv
package ppio_pkg;
  localparam int DW = 8;
  localparam int HW = DW / 2;
  localparam int IW = $clog2(DW);

  localparam logic [1:0] SEL_A   = 2'd0;
  localparam logic [1:0] SEL_B   = 2'd1;
  localparam logic [1:0] SEL_C   = 2'd2;
  localparam logic [1:0] SEL_CTL = 2'd3;

  // direction flags, 1 = input
  typedef struct packed {
    logic a_in;
    logic b_in;
    logic chi_in;
    logic clo_in;
  } dir_t;

  localparam dir_t DIR_RESET = '{a_in: 1'b1, b_in: 1'b1, chi_in: 1'b1, clo_in: 1'b1};

  function automatic dir_t dir_from_word(input logic [DW-1:0] w);
    dir_t d;
    d.a_in   = w[4];
    d.chi_in = w[3];
    d.b_in   = w[1];
    d.clo_in = w[0];
    return d;
  endfunction

  function automatic logic [DW-1:0] bit_update(input logic [DW-1:0] cur,
                                               input logic [DW-1:0] w);
    logic [DW-1:0] nxt;
    logic [IW-1:0] idx;
    nxt = cur;
    idx = w[IW:1];
    nxt[idx] = w[0];
    return nxt;
  endfunction

  function automatic logic [DW-1:0] pick(input logic is_in,
                                         input logic [DW-1:0] pins,
                                         input logic [DW-1:0] lat);
    return is_in ? pins : lat;
  endfunction
endpackage

// File: rtl/ppio_decode.sv
module ppio_decode
  import ppio_pkg::*;
(
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] din,
  output logic          wr_a,
  output logic          wr_b,
  output logic          wr_c,
  output logic          mode_wr,
  output logic          bsr_wr,
  output logic          rd_en
);
  logic wr_any;
  assign wr_any  = !cs_n && !wr_n;
  assign rd_en   = !cs_n && !rd_n;
  assign wr_a    = wr_any && (addr == SEL_A);
  assign wr_b    = wr_any && (addr == SEL_B);
  assign wr_c    = wr_any && (addr == SEL_C);
  assign mode_wr = wr_any && (addr == SEL_CTL) &&  din[DW-1];
  assign bsr_wr  = wr_any && (addr == SEL_CTL) && !din[DW-1];
endmodule

// File: rtl/ppio_latch.sv
module ppio_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (load)  q <= d;
  end
endmodule

// File: rtl/ppio_cfg.sv
module ppio_cfg
  import ppio_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_wr,
  input  logic [DW-1:0] din,
  output dir_t          dir
);
  always_ff @(posedge clk) begin
    if (rst)          dir <= DIR_RESET;
    else if (mode_wr) dir <= dir_from_word(din);
  end
endmodule

// File: rtl/ppio_ctrl.sv
module ppio_ctrl
  import ppio_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] dbus_i,
  output logic [DW-1:0] dbus_o,
  output logic          dbus_oe,
  input  logic [DW-1:0] pa_i,
  output logic [DW-1:0] pa_o,
  output logic [DW-1:0] pa_oe,
  input  logic [DW-1:0] pb_i,
  output logic [DW-1:0] pb_o,
  output logic [DW-1:0] pb_oe,
  input  logic [DW-1:0] pc_i,
  output logic [DW-1:0] pc_o,
  output logic [DW-1:0] pc_oe
);
  logic wr_a, wr_b, wr_c, mode_wr, bsr_wr, rd_en;
  dir_t dir;
  logic [DW-1:0] pc_next;
  logic [DW-1:0] pc_view;

  ppio_decode u_dec (
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .din(dbus_i),
    .wr_a(wr_a), .wr_b(wr_b), .wr_c(wr_c),
    .mode_wr(mode_wr), .bsr_wr(bsr_wr), .rd_en(rd_en)
  );

  ppio_cfg u_cfg (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .din(dbus_i), .dir(dir)
  );

  ppio_latch #(.W(DW)) u_la (
    .clk(clk), .rst(rst), .clr(mode_wr), .load(wr_a), .d(dbus_i), .q(pa_o)
  );
  ppio_latch #(.W(DW)) u_lb (
    .clk(clk), .rst(rst), .clr(mode_wr), .load(wr_b), .d(dbus_i), .q(pb_o)
  );

  assign pc_next = wr_c ? dbus_i : bit_update(pc_o, dbus_i);
  ppio_latch #(.W(DW)) u_lc (
    .clk(clk), .rst(rst), .clr(mode_wr), .load(wr_c || bsr_wr), .d(pc_next), .q(pc_o)
  );

  assign pa_oe = {DW{!dir.a_in}};
  assign pb_oe = {DW{!dir.b_in}};
  assign pc_oe = {{HW{!dir.chi_in}}, {HW{!dir.clo_in}}};

  assign pc_view = {pick(dir.chi_in, pc_i, pc_o) >> HW << HW}
                 | (pick(dir.clo_in, pc_i, pc_o) & {{HW{1'b0}}, {HW{1'b1}}});

  always_comb begin
    unique case (addr)
      SEL_A:   dbus_o = pick(dir.a_in, pa_i, pa_o);
      SEL_B:   dbus_o = pick(dir.b_in, pb_i, pb_o);
      SEL_C:   dbus_o = pc_view;
      default: dbus_o = '0;
    endcase
  end
  assign dbus_oe = rd_en;
endmodule

// File: rtl/ppio_chk.sv
module ppio_chk
  import ppio_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          mode_wr,
  input logic          bsr_wr,
  input logic          wr_a,
  input logic          wr_b,
  input logic [DW-1:0] pa_o,
  input logic [DW-1:0] pb_o,
  input logic [DW-1:0] pc_o,
  input logic [DW-1:0] pa_oe,
  input logic [DW-1:0] pb_oe,
  input logic [DW-1:0] pc_oe
);
  // R3
  reset_inputs_chk: assert property (@(posedge clk)
    rst |=> (pa_oe == '0 && pb_oe == '0 && pc_oe == '0 && pa_o == '0));

  // R5
  mode_clears_chk: assert property (@(posedge clk) disable iff (rst)
    mode_wr |=> (pa_o == '0 && pb_o == '0 && pc_o == '0));

  // R6
  bsr_one_bit_chk: assert property (@(posedge clk) disable iff (rst)
    bsr_wr |=> ($countones(pc_o ^ $past(pc_o)) <= 1));

  // R6
  bsr_dir_keep_chk: assert property (@(posedge clk) disable iff (rst)
    bsr_wr |=> ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe) && $stable(pa_o)));

  // R2
  hold_a_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_a || mode_wr) |=> $stable(pa_o));

  // R2
  hold_b_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_b || mode_wr) |=> $stable(pb_o));

  // R4
  whole_port_oe_chk: assert property (@(posedge clk) disable iff (rst)
    (pa_oe == '0 || pa_oe == '1) && (pb_oe == '0 || pb_oe == '1));
endmodule

bind ppio_ctrl ppio_chk u_chk (
  .clk(clk), .rst(rst), .mode_wr(mode_wr), .bsr_wr(bsr_wr),
  .wr_a(wr_a), .wr_b(wr_b),
  .pa_o(pa_o), .pb_o(pb_o), .pc_o(pc_o),
  .pa_oe(pa_oe), .pb_oe(pb_oe), .pc_oe(pc_oe)
);

// File: tb/sim_ppio_ctrl.sv
module sim_ppio_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] dbus_i = '0;
  logic [7:0] dbus_o;
  logic dbus_oe;
  logic [7:0] pa_i = '0, pb_i = '0, pc_i = '0;
  logic [7:0] pa_o, pa_oe, pb_o, pb_oe, pc_o, pc_oe;

  int n_run = 0;
  int n_fail = 0;
  logic rd_active = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ppio_ctrl u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .dbus_i(dbus_i), .dbus_o(dbus_o), .dbus_oe(dbus_oe),
    .pa_i(pa_i), .pa_o(pa_o), .pa_oe(pa_oe),
    .pb_i(pb_i), .pb_o(pb_o), .pb_oe(pb_oe),
    .pc_i(pc_i), .pc_o(pc_o), .pc_oe(pc_oe)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: reads are stable around the rising edge
  always @(posedge clk) begin
    if (rd_active && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      check({it.tag, " read"}, dbus_o, it.exp);
      check("R8 oe during read", {7'd0, dbus_oe}, 8'd1);
    end
  end

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, input logic sel = 1'b1);
    @(negedge clk);
    cs_n = !sel; wr_n = 1'b0; addr = a; dbus_i = d;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic bus_rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = a;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
    rd_active = 1'b1;
    @(negedge clk);
    rd_active = 1'b0;
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R3 reset state
    check("R3 pa_oe", pa_oe, 8'h00);
    check("R3 pb_oe", pb_oe, 8'h00);
    check("R3 pc_oe", pc_oe, 8'h00);
    check("R3 pa_o", pa_o, 8'h00);
    pa_i = 8'h5A;
    bus_rd(2'd0, 8'h5A, "R7 port A live pins");

    // R4 all outputs
    bus_wr(2'd3, 8'h80);
    @(negedge clk);
    check("R4 pa_oe", pa_oe, 8'hFF);
    check("R4 pb_oe", pb_oe, 8'hFF);
    check("R4 pc_oe", pc_oe, 8'hFF);
    // R1 decode
    bus_wr(2'd0, 8'h3C);
    bus_wr(2'd1, 8'hA5);
    bus_wr(2'd2, 8'h96);
    repeat (2) @(negedge clk);
    check("R2 pa_o held", pa_o, 8'h3C);
    check("R1 pb_o", pb_o, 8'hA5);
    check("R1 pc_o", pc_o, 8'h96);
    bus_rd(2'd0, 8'h3C, "R1 port A latch");
    bus_rd(2'd1, 8'hA5, "R1 port B latch");
    bus_rd(2'd2, 8'h96, "R1 port C latch");

    // R6 bit set/reset
    bus_wr(2'd3, 8'h0D);
    @(negedge clk);
    check("R6 set bit6", pc_o, 8'hD6);
    bus_wr(2'd3, 8'h04);
    @(negedge clk);
    check("R6 clear bit2", pc_o, 8'hD2);
    check("R6 pc_oe kept", pc_oe, 8'hFF);
    check("R6 pa_o kept", pa_o, 8'h3C);

    // R10 deselected write
    bus_wr(2'd0, 8'hFF, 1'b0);
    bus_wr(2'd3, 8'h9B, 1'b0);
    @(negedge clk);
    check("R10 pa_o unchanged", pa_o, 8'h3C);
    check("R10 pa_oe unchanged", pa_oe, 8'hFF);

    // R9 control not readable
    bus_rd(2'd3, 8'h00, "R9 control");

    // R5 mode write clears latches; C both halves input
    bus_wr(2'd3, 8'h89);
    @(negedge clk);
    check("R5 pa_o", pa_o, 8'h00);
    check("R5 pb_o", pb_o, 8'h00);
    check("R5 pc_o", pc_o, 8'h00);
    check("R4 pc_oe inputs", pc_oe, 8'h00);
    pc_i = 8'h7E;
    bus_rd(2'd2, 8'h7E, "R7 port C pins");

    // R4/R7 mixed nibbles: upper out, lower in
    bus_wr(2'd3, 8'h81);
    bus_wr(2'd2, 8'hA3);
    @(negedge clk);
    check("R4 pc_oe mixed", pc_oe, 8'hF0);
    bus_rd(2'd2, 8'hAE, "R7 port C mixed");

    // R4 A,B input; C output
    bus_wr(2'd3, 8'h92);
    @(negedge clk);
    check("R4 pa_oe input", pa_oe, 8'h00);
    check("R4 pb_oe input", pb_oe, 8'h00);
    check("R4 pc_oe output", pc_oe, 8'hFF);
    pa_i = 8'h11; pb_i = 8'h22;
    bus_wr(2'd1, 8'h44);
    bus_rd(2'd0, 8'h11, "R7 port A input");
    bus_rd(2'd1, 8'h22, "R7 port B input after write");

    // R8 no drive without select
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b0;
    #1 check("R8 oe deselected", {7'd0, dbus_oe}, 8'd0);
    @(negedge clk);
    rd_n = 1'b1; cs_n = 1'b0;
    #1 check("R8 oe no strobe", {7'd0, dbus_oe}, 8'd0);
    cs_n = 1'b1;

    repeat (2) @(negedge clk);
    if (sb.size() != 0) begin
      n_run++; n_fail++;
      $display("FAIL scoreboard left=%0d expected=0", sb.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule